// File: doc/BRIEF.md
# Streaming Dot Product Unit

This block forms the inner product of two equal-length vectors that arrive one element pair per clock cycle, lowest index first. Each pair is multiplied and the product is added into a running sum. Nothing on the input side marks when a vector starts. The block counts the pairs itself and treats every group of `VEC_LEN` consecutive cycles after reset as one vector.

When the last pair of a vector has been taken in, the block registers the completed sum on its result port and raises a valid strobe for exactly one cycle. In that same cycle the running sum is cleared, so a new vector can follow at once with no idle cycle. All arithmetic wraps modulo 2^`WORD_W`, so two's-complement operands give the correct low-order bits.

The design has a control part and a datapath part. The control part holds the element index and issues strobes. The datapath part holds the multiplier, the accumulator and the result register.

Top module: `dot_stream`

## Requirements
- R1: While `rstN` is low at a rising clock edge, the edge leaves `sumValid` at 0 and `sumOut` at 0.
- R2: After reset is released, `sumValid` is high for exactly one cycle out of every `VEC_LEN` cycles. The first pulse follows the `VEC_LEN`-th rising edge with `rstN` high.
- R3: In a cycle where `sumValid` is high, `sumOut` equals the sum of `aElem*bElem` over the `VEC_LEN` pairs sampled at the preceding `VEC_LEN` rising edges.
- R4: Vectors streamed back to back give independent results. No contribution from one vector appears in the next vector's sum.
- R5: Products and sums are truncated to `WORD_W` bits (arithmetic modulo 2^`WORD_W`). For example, 0xFFFFFFFF times 0xFFFFFFFF adds 1 to the sum.
- R6: Between valid pulses, `sumOut` keeps the last result, or 0 if no result has been produced since reset.
- R7: Asserting reset in the middle of a vector discards the partial sum and the element index. The next vector starts with the first pair sampled after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| aElem | input | WORD_W | Element of vector A, consumed every cycle |
| bElem | input | WORD_W | Element of vector B with the same index |
| sumOut | output | WORD_W | Most recent completed dot product |
| sumValid | output | 1 | One-cycle strobe marking a new result on `sumOut` |

## Verification
If the element index slips, the valid pulses stop coming exactly `VEC_LEN` cycles apart. Each result then also covers pairs from two different vectors, which shows up at the very next pulse. If the accumulator is not flushed, the first result can still look correct, but the error appears as a wrong sum on the second back-to-back vector. A missing truncation or a wrong reset of the index shows up only with operands near the word limit or after a reset in the middle of a vector. For that reason the stimulus includes all-ones operands, products that overflow to zero, and a reset partway through a vector.

// File: rtl/dot_stream_pkg.sv
package dot_stream_pkg;

  // Strobes from the index controller to the arithmetic datapath.
  typedef struct packed {
    logic accClear;    // start the next vector from zero
    logic resultLoad;  // capture the completed sum and raise valid
  } dotStrobes_t;

endpackage

// File: rtl/dot_stream_ctrl.sv
module dot_stream_ctrl
  import dot_stream_pkg::*;
#(
  parameter int VEC_LEN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  output dotStrobes_t strobes
);

  logic lastElem;

  generate
    if (VEC_LEN == 1) begin : g_single
      // Every pair is a whole vector.
      assign lastElem = 1'b1;
    end else begin : g_count
      localparam int IDX_W = $clog2(VEC_LEN);
      localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VEC_LEN - 1);

      logic [IDX_W-1:0] elemIdx;

      always_ff @(posedge clk) begin
        if (!rstN)               elemIdx <= '0;
        else if (elemIdx == LAST_IDX) elemIdx <= '0;
        else                     elemIdx <= elemIdx + 1'b1;
      end

      assign lastElem = (elemIdx == LAST_IDX);

      // R2: the index never leaves the range 0..VEC_LEN-1
      a_r2_idx_range : assert property (@(posedge clk) disable iff (!rstN)
        elemIdx <= LAST_IDX);

      // R2: after the final index the count restarts at zero
      a_r2_idx_wrap : assert property (@(posedge clk) disable iff (!rstN)
        (elemIdx == LAST_IDX) |=> (elemIdx == '0));

      // R2: a result strobe is never issued in two cycles in a row
      a_r2_single_pulse : assert property (@(posedge clk) disable iff (!rstN)
        strobes.resultLoad |=> !strobes.resultLoad);
    end
  endgenerate

  always_comb begin
    strobes.accClear   = lastElem;
    strobes.resultLoad = lastElem;
  end

endmodule

// File: rtl/dot_stream_dp.sv
module dot_stream_dp
  import dot_stream_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] aElem,
  input  logic [WORD_W-1:0] bElem,
  input  dotStrobes_t       strobes,
  output logic [WORD_W-1:0] sumOut,
  output logic              sumValid
);

  logic [WORD_W-1:0] prodW;
  logic [WORD_W-1:0] accQ;
  logic [WORD_W-1:0] accNext;
  logic [WORD_W-1:0] sumQ;
  logic              validQ;

  // Low WORD_W bits of the product: modulo arithmetic for signed or unsigned.
  assign prodW   = aElem * bElem;
  assign accNext = accQ + prodW;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ   <= '0;
      sumQ   <= '0;
      validQ <= 1'b0;
    end else begin
      accQ   <= strobes.accClear ? '0 : accNext;
      if (strobes.resultLoad) sumQ <= accNext;
      validQ <= strobes.resultLoad;
    end
  end

  assign sumOut   = sumQ;
  assign sumValid = validQ;

  // R4: whenever a result is presented, the running sum has been flushed
  a_r4_flushed_on_valid : assert property (@(posedge clk) disable iff (!rstN)
    sumValid |-> (accQ == '0));

  // R6: without a load strobe the result register keeps its value
  a_r6_result_hold : assert property (@(posedge clk) disable iff (!rstN)
    !strobes.resultLoad |=> $stable(sumOut));

  // R2: valid follows the load strobe by exactly one cycle
  a_r2_valid_follows_load : assert property (@(posedge clk) disable iff (!rstN)
    strobes.resultLoad |=> sumValid);

endmodule

// File: rtl/dot_stream.sv
module dot_stream
  import dot_stream_pkg::*;
#(
  parameter int VEC_LEN = 4,
  parameter int WORD_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] aElem,
  input  logic [WORD_W-1:0] bElem,
  output logic [WORD_W-1:0] sumOut,
  output logic              sumValid
);

  dotStrobes_t strobes;

  dot_stream_ctrl #(.VEC_LEN(VEC_LEN)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes)
  );

  dot_stream_dp #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .aElem    (aElem),
    .bElem    (bElem),
    .strobes  (strobes),
    .sumOut   (sumOut),
    .sumValid (sumValid)
  );

endmodule

// File: tb/dot_stream_tb.sv
module dot_stream_tb;

  localparam int N = 4;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] aElem = '0;
  logic [W-1:0] bElem = '0;
  logic [W-1:0] sumOut;
  logic         sumValid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [W-1:0] expQ[$];
  string        tagQ[$];
  logic [W-1:0] lastRes = '0;
  int           since = 0;

  always #4 clk = ~clk;  // 125 MHz

  dot_stream #(.VEC_LEN(N), .WORD_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .aElem(aElem), .bElem(bElem),
    .sumOut(sumOut), .sumValid(sumValid)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: streams one vector, optionally releasing reset with its first pair,
  // and queues the expected sum from the modular model.
  task automatic sendVec(input int kind, input string tag, input bit relRst);
    logic [W-1:0] acc = '0;
    for (int i = 0; i < N; i++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      case (kind)
        1:       begin a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; end
        2:       begin a = 32'h8000_0000; b = 32'd2 + W'(i); end
        3:       begin a = '0;            b = $urandom; end
        4:       begin a = W'(i + 1);     b = -W'(2 * i + 1); end
        default: begin a = $urandom;      b = $urandom; end
      endcase
      @(negedge clk);
      if (relRst && i == 0) rstN = 1'b1;
      aElem = a;
      bElem = b;
      acc = acc + a * b;
    end
    expQ.push_back(acc);
    tagQ.push_back(tag);
  endtask

  // Monitor: samples after each rising edge, away from the driver's edge.
  always @(posedge clk) begin
    #2;
    if (!rstN) begin
      check(sumValid == 1'b0, "R1 valid", {31'b0, sumValid}, '0);
      check(sumOut == '0, "R1 sum", sumOut, '0);
      lastRes = '0;
      since = 0;
    end else begin
      since++;
      if (sumValid) begin
        check(since == N, "R2 spacing", W'(since), W'(N));
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected pulse", sumOut, '0);
        end else begin
          logic [W-1:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(sumOut == e, t, sumOut, e);
        end
        lastRes = sumOut;
        since = 0;
      end else begin
        check(sumOut == lastRes, "R6 hold", sumOut, lastRes);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    sendVec(4, "R3 mixed signs", 1'b1);
    sendVec(0, "R4 back-to-back random", 1'b0);
    sendVec(3, "R4 zero vector after nonzero", 1'b0);
    sendVec(1, "R5 all-ones wrap", 1'b0);
    sendVec(2, "R5 product overflow", 1'b0);
    for (int k = 0; k < 6; k++) sendVec(0, "R3 random", 1'b0);
    // R7: partial vector, then reset in the middle
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      aElem = 32'd1000 + W'(i);
      bElem = 32'd7;
    end
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    sendVec(0, "R7 after mid-vector reset", 1'b1);
    sendVec(4, "R7 second after reset", 1'b0);
    @(posedge clk);
    #3;
    check(expQ.size() == 0, "R2 all results seen", W'(expQ.size()), '0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule